// File: doc/BRIEF.md
# De Bruijn Up/Down Shift Counter

This block is a 3-bit position counter made from a shift register with nonlinear feedback instead of an incrementer. It steps through all eight 3-bit codes in a fixed cyclic order that is not binary: 000, 001, 010, 101, 011, 111, 110, 100, then back to 000. Each step shifts the register by one place and inserts a single computed bit. No carry chain is involved.

An up strobe moves the state one place forward in that order. A down strobe moves it one place back. The state is registered and drives the output directly, so it can serve as a small address into storage. Storage that is always written and read in the same order does not need binary addresses. A parameter builds an up-only variant that has no backward-step logic. That variant suits a free-running sweep, such as walking through a set of entries one after another.

Top module: `dbr_shift_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state loads `RESET_STATE` (default 000), whatever `up` and `down` are.
- R2: With only `up` asserted, the state moves forward one place in the order 000, 001, 010, 101, 011, 111, 110, 100, and goes from 100 back to 000.
- R3: On a forward step, new bits [2:1] equal old bits [1:0]. New bit 0 is 1 exactly when the old state was 000, 010, 011 or 101.
- R4: With `UP_ONLY=0` and only `down` asserted, the state moves back one place in the order above, and goes from 000 to 100. New bits [1:0] equal old bits [2:1]. New bit 2 is 1 exactly when the old state was 000, 011, 100 or 110.
- R5: A forward step followed by a backward step returns the state it started from, for every start state.
- R6: With `UP_ONLY=0`, when `up` and `down` are both high, or both low, the state holds.
- R7: Starting from any state, eight forward steps visit each of the eight codes exactly once and then return to the start.
- R8: With `UP_ONLY=1`, `down` has no effect. With `down` alone the state holds, and with `up` and `down` together the state steps forward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| up | input | 1 | Step forward one place in the sequence |
| down | input | 1 | Step back one place (ignored when `UP_ONLY=1`) |
| state | output | 3 | Current register contents, used directly as an address |

## Verification
Two boundaries are hardest to reach from the ports: the wrap between 100 and 000 in each direction, and a backward step taken from each of the eight states. The stimulus walks backward from reset so that the first step already crosses 000 to 100. It also pairs a forward and a backward step at every point of a full forward lap. Both variants receive the same input stream, including cycles where both strobes are high and cycles where reset coincides with a strobe. This shows that the variants diverge only where `down` matters.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

   localparam int unsigned DBR_W   = 3;
   localparam int unsigned DBR_LEN = 1 << DBR_W;

   typedef logic [DBR_W-1:0] dbr_state_t;

   typedef enum logic [1:0] {
      STEP_HOLD = 2'b00,
      STEP_FWD  = 2'b01,
      STEP_BWD  = 2'b10
   } dbr_step_e;

   typedef enum logic {
      FB_FWD = 1'b0,
      FB_BWD = 1'b1
   } dbr_dir_e;

endpackage

// File: rtl/dbr_step_decode.sv
module dbr_step_decode
   import dbr_pkg::*;
#(
   parameter bit UP_ONLY = 1'b0
) (
   input  logic      up,
   input  logic      down,
   output dbr_step_e step
);

   generate
      if (UP_ONLY) begin : g_fwd_only
         always_comb step = up ? STEP_FWD : STEP_HOLD;
      end else begin : g_both
         always_comb begin
            unique case ({up, down})
               2'b10:   step = STEP_FWD;
               2'b01:   step = STEP_BWD;
               default: step = STEP_HOLD;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/dbr_feedback.sv
module dbr_feedback
   import dbr_pkg::*;
#(
   parameter dbr_dir_e DIR = FB_FWD
) (
   input  dbr_state_t cur,
   output logic       fb
);

   generate
      if (DIR == FB_FWD) begin : g_fwd
         always_comb begin
            unique case (cur)
               3'b000, 3'b010, 3'b011, 3'b101: fb = 1'b1;
               default:                        fb = 1'b0;
            endcase
         end
      end else begin : g_bwd
         always_comb begin
            unique case (cur)
               3'b000, 3'b011, 3'b100, 3'b110: fb = 1'b1;
               default:                        fb = 1'b0;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/dbr_shift_reg.sv
module dbr_shift_reg
   import dbr_pkg::*;
#(
   parameter dbr_state_t RESET_STATE = '0
) (
   input  logic       clk,
   input  logic       rst,
   input  dbr_step_e  step,
   input  logic       fb_fwd,
   input  logic       fb_bwd,
   output dbr_state_t q
);

   dbr_state_t nxt;

   always_comb begin
      unique case (step)
         STEP_FWD: nxt = {q[DBR_W-2:0], fb_fwd};
         STEP_BWD: nxt = {fb_bwd, q[DBR_W-1:1]};
         default:  nxt = q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) q <= RESET_STATE;
      else     q <= nxt;
   end

endmodule

// File: rtl/dbr_shift_counter.sv
module dbr_shift_counter
   import dbr_pkg::*;
#(
   parameter bit         UP_ONLY     = 1'b0,
   parameter dbr_state_t RESET_STATE = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             up,
   input  logic             down,
   output logic [DBR_W-1:0] state
);

   generate
      if (DBR_W != 3) begin : g_bad_width
         $error("dbr_shift_counter: feedback tables are built for a 3-bit register");
      end
      if (DBR_LEN != 8) begin : g_bad_len
         $error("dbr_shift_counter: period must equal 2**width");
      end
   endgenerate

   dbr_step_e  step;
   dbr_state_t q;
   logic       fb_fwd;
   logic       fb_bwd;

   dbr_step_decode #(.UP_ONLY(UP_ONLY)) u_dec (
      .up   (up),
      .down (down),
      .step (step)
   );

   dbr_feedback #(.DIR(FB_FWD)) u_fb_fwd (
      .cur (q),
      .fb  (fb_fwd)
   );

   generate
      if (UP_ONLY) begin : g_no_bwd
         assign fb_bwd = 1'b0;
      end else begin : g_bwd
         dbr_feedback #(.DIR(FB_BWD)) u_fb_bwd (
            .cur (q),
            .fb  (fb_bwd)
         );
      end
   endgenerate

   dbr_shift_reg #(.RESET_STATE(RESET_STATE)) u_reg (
      .clk    (clk),
      .rst    (rst),
      .step   (step),
      .fb_fwd (fb_fwd),
      .fb_bwd (fb_bwd),
      .q      (q)
   );

   assign state = q;

endmodule

// File: rtl/dbr_shift_counter_chk.sv
module dbr_shift_counter_chk
   import dbr_pkg::*;
#(
   parameter bit         UP_ONLY     = 1'b0,
   parameter dbr_state_t RESET_STATE = '0
) (
   input logic             clk,
   input logic             rst,
   input logic             up,
   input logic             down,
   input logic [DBR_W-1:0] state
);

   logic fwd_req;
   logic bwd_req;
   assign fwd_req = UP_ONLY ? up : (up && !down);
   assign bwd_req = !UP_ONLY && down && !up;

   // R1
   p_reset_load_r1: assert property (@(posedge clk)
      rst |=> state == RESET_STATE);

   // R3
   p_fwd_shift_r3: assert property (@(posedge clk) disable iff (rst)
      fwd_req |=> state[2:1] == $past(state[1:0]));

   // R2
   p_fwd_wrap_r2: assert property (@(posedge clk) disable iff (rst)
      (fwd_req && state == 3'b100) |=> state == 3'b000);

   // R2
   p_fwd_moves_r2: assert property (@(posedge clk) disable iff (rst)
      fwd_req |=> state != $past(state));

   // R6 / R8
   p_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (!fwd_req && !bwd_req) |=> $stable(state));

   generate
      if (!UP_ONLY) begin : g_bwd_chk
         // R4
         p_bwd_shift_r4: assert property (@(posedge clk) disable iff (rst)
            bwd_req |=> state[1:0] == $past(state[2:1]));
         // R4
         p_bwd_wrap_r4: assert property (@(posedge clk) disable iff (rst)
            (bwd_req && state == 3'b000) |=> state == 3'b100);
      end
   endgenerate

endmodule

bind dbr_shift_counter dbr_shift_counter_chk #(
   .UP_ONLY     (UP_ONLY),
   .RESET_STATE (RESET_STATE)
) u_chk (
   .clk   (clk),
   .rst   (rst),
   .up    (up),
   .down  (down),
   .state (state)
);

// File: tb/tb_dbr_shift_counter.sv
`timescale 1ns/1ps
module tb_dbr_shift_counter;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       up  = 1'b0;
   logic       down = 1'b0;
   logic [2:0] st_bi;
   logic [2:0] st_uo;

   int n_run  = 0;
   int n_fail = 0;

   // forward visiting order, by position
   int order [8] = '{0, 1, 2, 5, 3, 7, 6, 4};
   int pos_bi = 0;
   int pos_uo = 0;

   always #5 clk = ~clk;

   dbr_shift_counter #(.UP_ONLY(1'b0)) dut (
      .clk(clk), .rst(rst), .up(up), .down(down), .state(st_bi));

   dbr_shift_counter #(.UP_ONLY(1'b1)) dut_up (
      .clk(clk), .rst(rst), .up(up), .down(down), .state(st_uo));

   task automatic check(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: state=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // called at a falling edge: drive, clock, update model, compare
   task automatic cyc(input logic r, input logic u, input logic d, input string tag);
      rst = r; up = u; down = d;
      @(posedge clk);
      if (r) begin
         pos_bi = 0; pos_uo = 0;
      end else begin
         if (u && !d)      pos_bi = (pos_bi + 1) % 8;
         else if (d && !u) pos_bi = (pos_bi + 7) % 8;
         if (u)            pos_uo = (pos_uo + 1) % 8;
      end
      @(negedge clk);
      check(tag, int'(st_bi), order[pos_bi]);
      check({tag, "/up-only"}, int'(st_uo), order[pos_uo]);
   endtask

   initial begin : watchdog
      #(200000 * 10);
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : stim
      int seen;
      int start;
      @(negedge clk);
      cyc(1'b1, 1'b0, 1'b0, "R1 reset");
      cyc(1'b0, 1'b0, 1'b0, "R6 idle");

      // R4: backward from reset wraps 000 -> 100, full lap back
      for (int i = 0; i < 8; i++) cyc(1'b0, 1'b0, 1'b1, "R4 backward / R8 down ignored");

      // R2, R3, R7: full forward lap with visit tracking
      start = int'(st_bi);
      seen = 0;
      for (int i = 0; i < 8; i++) begin
         cyc(1'b0, 1'b1, 1'b0, "R2 R3 forward");
         seen = seen | (1 << st_bi);
      end
      check("R7 all codes visited", seen, 255);
      check("R7 lap returns to start", int'(st_bi), start);

      // R5: forward then backward at every position
      for (int i = 0; i < 8; i++) begin
         start = int'(st_bi);
         cyc(1'b0, 1'b1, 1'b0, "R5 forward half");
         cyc(1'b0, 1'b0, 1'b1, "R5 backward half");
         check("R5 restore", int'(st_bi), start);
         cyc(1'b0, 1'b1, 1'b0, "R5 advance");
      end

      // R6 and R8: both strobes together
      for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 1'b1, "R6 both hold / R8 up-only steps");
      cyc(1'b0, 1'b0, 1'b0, "R6 idle hold");

      // R1: reset wins over strobes
      cyc(1'b1, 1'b1, 1'b0, "R1 reset with up");
      cyc(1'b0, 1'b1, 1'b0, "R2 first step");
      cyc(1'b1, 1'b0, 1'b1, "R1 reset with down");
      check("R1 bidirectional at 000", int'(st_bi), 0);
      check("R8 up-only at 000", int'(st_uo), 0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule